// File: doc/BRIEF.md
# Cache-Line Store Backup Queue

This block keeps an ordered record of stores that were made to cacheable lines, so that a later line invalidation can undo the cache's view by replaying the recorded store to memory. Each record holds a word address and a data word. Records are appended at the tail in arrival order. An invalidate command names a line address. The block searches from the oldest record for the first one whose address falls in the same 32-byte line. It issues that record as one memory write and unlinks only that record, so the records before and after it keep their relative order.

A discard strobe drops every record at once. The memory write leaves through a valid/ready handshake. While a write waits to be accepted, the block raises `busy` and ignores every command. A push to a full queue is dropped and flagged. Cache arrays, cacheability decoding and the memory itself live outside the block.

Top module: `line_backup_queue`

## Requirements
- R1: A push is recorded only when `push_cacheable` is 1. A push with `push_cacheable` 0 changes nothing and raises no flag.
- R2: Records keep arrival order. When several records share a line, successive invalidates of that line replay them oldest first.
- R3: Two addresses are in the same line when they are equal after their low 5 bits are cleared. The low 5 bits of `inv_addr` play no part in the match.
- R4: An invalidate that hits presents the record's own stored address and data on `mem_waddr` and `mem_wdata`. `mem_wvalid` rises in the cycle after the command edge. The record is then gone, so a later invalidate of that line with no other record in it produces no write.
- R5: Removing a record from any position, including the tail, leaves the other records in their order and frees one slot. The next push is appended after the youngest survivor.
- R6: A discard empties the queue. After it, no invalidate produces a write until new pushes arrive.
- R7: A cacheable push into a full queue (DEPTH records) is dropped and the existing records stay intact. `overflow` is 1 for exactly the one cycle after that command edge and 0 otherwise.
- R8: An invalidate that matches no record issues no write and leaves the queue unchanged.
- R9: When strobes coincide in one accepted cycle, discard beats invalidate and invalidate beats push. Only the winning command takes effect.
- R10: `mem_wvalid`, `mem_waddr` and `mem_wdata` hold steady until `mem_wready` is seen high at a clock edge. `busy` equals `mem_wvalid`. Push, invalidate and discard presented while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_vld | input | 1 | Push command strobe |
| push_cacheable | input | 1 | Push target is cacheable; the push is recorded only when this is 1 |
| push_addr | input | AW | Store address to record |
| push_data | input | DW | Store data to record |
| inv_vld | input | 1 | Invalidate command strobe |
| inv_addr | input | AW | Address inside the line to invalidate |
| discard | input | 1 | Drop all records |
| busy | output | 1 | A replay write is pending; commands are ignored |
| overflow | output | 1 | One-cycle flag: a push hit a full queue |
| mem_wvalid | output | 1 | Replay write valid |
| mem_wready | input | 1 | Memory accepts the replay write |
| mem_waddr | output | AW | Replay write address |
| mem_wdata | output | DW | Replay write data |

## Verification
The assertions assume two things about the inputs. The memory side eventually raises `mem_wready`. No command is counted on while `busy` is high, because the design drops such commands instead of queuing them. The stimulus keeps within these limits. It raises `mem_wready` after a bounded stall, and it presents commands during a stall only to show that they vanish. Expected replays come from an arithmetic model of an ordered list in the bench. The main sweep covers every queue fill from one to DEPTH and every hit position in it, then drains the remaining records to confirm their order.

// File: rtl/lbq_pkg.sv
// Shared types for the line backup queue.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package lbq_pkg;

    // Command selected in one cycle after arbitration and the stall
    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_DISCARD = 2'd1,
        CMD_INVAL   = 2'd2,
        CMD_PUSH    = 2'd3
    } lbq_cmd_e;

endpackage

// File: rtl/lbq_store.sv
// Ordered record storage. Slot 0 is the oldest record and slot count-1
// the youngest. Append writes slot count. Remove at index k shifts every
// younger slot down by one, so arrival order survives.
// Assumes: at most one of clear/rm_en/app_en per cycle; app_en never when
// full; rm_en only with rm_idx < count.
module lbq_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       app_en,
    input  logic [AW-1:0]              app_addr,
    input  logic [DW-1:0]              app_data,
    input  logic                       rm_en,
    input  logic [IW-1:0]              rm_idx,
    output logic [DEPTH-1:0][AW-1:0]   ent_addr,
    output logic [DEPTH-1:0][DW-1:0]   ent_data,
    output logic [CW-1:0]              count,
    output logic                       full
);

    logic [DEPTH-1:0][AW-1:0] addr_q;
    logic [DEPTH-1:0][DW-1:0] data_q;
    logic [CW-1:0]            count_q;

    // Occupancy counter: clear, shrink on remove, grow on append
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (rm_en) begin
            count_q <= count_q - CW'(1);
        end else if (app_en) begin
            count_q <= count_q + CW'(1);
        end
    end

    // Slot contents: compact on remove, write the tail slot on append
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (rm_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IW'(i) >= rm_idx) begin
                    addr_q[i] <= addr_q[i+1];
                    data_q[i] <= data_q[i+1];
                end
            end
        end else if (app_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == count_q) begin
                    addr_q[i] <= app_addr;
                    data_q[i] <= app_data;
                end
            end
        end
    end

    assign ent_addr = addr_q;
    assign ent_data = data_q;
    assign count    = count_q;
    assign full     = (count_q == CW'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_en |-> (count_q < CW'(DEPTH)));

    // R1
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (app_en && !clear && !rm_en) |=> (count_q == $past(count_q) + CW'(1)));

    // R5
    shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_en && !clear) |=> (count_q == $past(count_q) - CW'(1)));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0));

endmodule

// File: rtl/lbq_match.sv
// Oldest-first line matcher. Compares the line part of the request with
// the line part of every occupied slot. Reports the lowest index that
// matches, which is the oldest matching record.
// Assumes: slot index order equals arrival order.
module lbq_match #(
    parameter int DEPTH = 4,
    parameter int LW    = 27,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][LW-1:0] ent_line,
    input  logic [CW-1:0]            count,
    input  logic [LW-1:0]            req_line,
    output logic                     hit,
    output logic [IW-1:0]            idx
);

    // Priority search, youngest to oldest, so the oldest hit is the one kept
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if ((CW'(i) < count) && (ent_line[i] == req_line)) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lbq_wport.sv
// Replay write port. Holds one address/data pair with a valid flag until
// the memory takes it with ready.
// Assumes: load is raised only while no write is pending.
module lbq_wport #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic          wvalid,
    input  logic          wready,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);

    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Valid flag: set on load, cleared when the handshake completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (load) begin
            vld_q <= 1'b1;
        end else if (vld_q && wready) begin
            vld_q <= 1'b0;
        end
    end

    // Payload register: captured on load only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            data_q <= load_data;
        end
    end

    assign wvalid = vld_q;
    assign waddr  = addr_q;
    assign wdata  = data_q;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !wready) |=> (vld_q && $stable(addr_q) && $stable(data_q)));

    // R10
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !vld_q);

endmodule

// File: rtl/line_backup_queue.sv
// Line backup queue top. Arbitrates the three commands (discard, then
// invalidate, then cacheable push), stalls them all while a replay write
// is pending, and steers the matched record into the write port.
// Assumes: the memory eventually raises mem_wready; a caller that needs a
// command to land keeps it off while busy is high.
module line_backup_queue
    import lbq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int LINE_BITS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_vld,
    input  logic          push_cacheable,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          inv_vld,
    input  logic [AW-1:0] inv_addr,
    input  logic          discard,
    output logic          busy,
    output logic          overflow,
    output logic          mem_wvalid,
    input  logic          mem_wready,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int LW = AW - LINE_BITS;

    lbq_cmd_e                 cmd;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [DEPTH-1:0][LW-1:0] ent_line;
    logic [CW-1:0]            count;
    logic                     full;
    logic                     hit;
    logic [IW-1:0]            hit_idx;
    logic                     rm_en;
    logic                     app_en;
    logic                     wvalid;
    logic                     ovf_q;

    // Command arbitration: stall while busy, discard > invalidate > push
    always_comb begin
        if (wvalid)                             cmd = CMD_IDLE;
        else if (discard)                       cmd = CMD_DISCARD;
        else if (inv_vld)                       cmd = CMD_INVAL;
        else if (push_vld && push_cacheable)    cmd = CMD_PUSH;
        else                                    cmd = CMD_IDLE;
    end

    assign rm_en  = (cmd == CMD_INVAL) && hit;
    assign app_en = (cmd == CMD_PUSH) && !full;

    // Line part of each stored address, fed to the matcher
    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        assign ent_line[g] = ent_addr[g][AW-1:LINE_BITS];
    end

    lbq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd == CMD_DISCARD),
        .app_en   (app_en),
        .app_addr (push_addr),
        .app_data (push_data),
        .rm_en    (rm_en),
        .rm_idx   (hit_idx),
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .count    (count),
        .full     (full)
    );

    lbq_match #(.DEPTH(DEPTH), .LW(LW)) u_match (
        .ent_line (ent_line),
        .count    (count),
        .req_line (inv_addr[AW-1:LINE_BITS]),
        .hit      (hit),
        .idx      (hit_idx)
    );

    lbq_wport #(.AW(AW), .DW(DW)) u_wport (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rm_en),
        .load_addr (ent_addr[hit_idx]),
        .load_data (ent_data[hit_idx]),
        .wvalid    (wvalid),
        .wready    (mem_wready),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata)
    );

    // Overflow flag: one cycle after a cacheable push meets a full queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= (cmd == CMD_PUSH) && full;
        end
    end

    assign busy       = wvalid;
    assign mem_wvalid = wvalid;
    assign overflow   = ovf_q;

    // R9
    discard_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && discard) |=> (!mem_wvalid && !overflow));

    // R8
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !discard && inv_vld && !hit) |=> !mem_wvalid);

    // R3
    match_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (CW'(hit_idx) < count));

    // R10
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !overflow);

    // R4
    replay_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !discard && inv_vld && hit) |=> mem_wvalid);

endmodule

// File: tb/tb_line_backup_queue.sv
module tb_line_backup_queue;

    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_vld = 1'b0;
    logic          push_cacheable = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic [DW-1:0] push_data = '0;
    logic          inv_vld = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic          discard = 1'b0;
    logic          busy;
    logic          overflow;
    logic          mem_wvalid;
    logic          mem_wready = 1'b0;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] m_addr[$];
    logic [31:0] m_data[$];

    always #2 clk = ~clk;

    line_backup_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .push_vld(push_vld), .push_cacheable(push_cacheable),
        .push_addr(push_addr), .push_data(push_data),
        .inv_vld(inv_vld), .inv_addr(inv_addr), .discard(discard),
        .busy(busy), .overflow(overflow),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One command cycle with any mix of strobes; model decides the outcome.
    // stall: cycles mem_wready stays low; junk: drive commands during stall.
    task automatic issue(input bit d, input bit i, input bit p, input bit c,
                         input logic [31:0] ia, input logic [31:0] pa,
                         input logic [31:0] pd, input int stall, input bit junk,
                         input string req);
        int  hit_i;
        bit  exp_ovf;
        hit_i = -1;
        exp_ovf = 1'b0;
        @(negedge clk);
        discard = d; inv_vld = i; inv_addr = ia;
        push_vld = p; push_cacheable = c; push_addr = pa; push_data = pd;
        @(posedge clk);
        @(negedge clk);
        discard = 0; inv_vld = 0; push_vld = 0; push_cacheable = 0;
        if (d) begin
            m_addr.delete(); m_data.delete();
        end else if (i) begin
            foreach (m_addr[k]) if (hit_i < 0 && (m_addr[k] >> 5) == (ia >> 5)) hit_i = k;
        end else if (p && c) begin
            if (m_addr.size() == DEPTH) exp_ovf = 1'b1;
            else begin m_addr.push_back(pa); m_data.push_back(pd); end
        end
        chk(overflow == exp_ovf, (p && c) ? "R7" : "R1", "overflow", 64'(overflow), 64'(exp_ovf));
        if (hit_i < 0) begin
            chk(mem_wvalid == 1'b0, i ? "R8" : "R9", "no replay", 64'(mem_wvalid), 0);
        end else begin
            chk(mem_wvalid && busy, "R4", "replay valid", 64'(mem_wvalid), 1);
            chk(mem_waddr == m_addr[hit_i], req, "replay addr", 64'(mem_waddr), 64'(m_addr[hit_i]));
            chk(mem_wdata == m_data[hit_i], req, "replay data", 64'(mem_wdata), 64'(m_data[hit_i]));
            for (int s = 0; s < stall; s++) begin
                if (junk) begin
                    push_vld = 1; push_cacheable = 1; push_addr = 32'h7FFF_FFE0;
                    push_data = 32'hDEAD; discard = (s == 0);
                end
                @(posedge clk);
                @(negedge clk);
                push_vld = 0; push_cacheable = 0; discard = 0;
                chk(mem_wvalid && busy && mem_waddr == m_addr[hit_i]
                    && mem_wdata == m_data[hit_i], "R10", "hold while stalled",
                    64'(mem_wdata), 64'(m_data[hit_i]));
            end
            mem_wready = 1;
            @(posedge clk);
            @(negedge clk);
            mem_wready = 0;
            chk(!mem_wvalid && !busy, "R10", "released", 64'(mem_wvalid), 0);
            m_addr.delete(hit_i); m_data.delete(hit_i);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d, input bit c);
        issue(0, 0, 1, c, 0, a, d, 0, 0, "R1");
    endtask

    task automatic inval(input logic [31:0] a, input int stall, input string req);
        issue(0, 1, 0, 0, a, 0, 0, stall, 0, req);
    endtask

    task automatic drop_all();
        issue(1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    endtask

    // Replays the whole model front to back: proves content and order
    task automatic drain(input string req);
        while (m_addr.size() > 0) inval(m_addr[0] ^ 32'h1F, 1, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk(!mem_wvalid && !busy && !overflow, "R10", "reset state", 64'(mem_wvalid), 0);

        // R8: invalidate on empty queue
        inval(32'h0000_1000, 0, "R8");

        // R1: non-cacheable push is not recorded
        push(32'h0000_2004, 32'h1111, 0);
        inval(32'h0000_2000, 0, "R1");

        // R3/R4/R5: every fill and every hit position, then drain
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) begin
                drop_all();
                for (int j = 0; j < n; j++)
                    push(32'h0001_0000 + (j << 5) + (j * 4 + 4), 32'h100 * n + 16 * k + j, 1);
                // low bits flipped: still the same line (R3)
                inval((32'h0001_0000 + (k << 5)) ^ 32'h1C, k, "R3");
                push(32'h0002_0000 + (k << 5), 32'hA000 + 32'(n), 1);   // R5 tail reuse
                drain("R5");
            end
        end

        // R2: same line, oldest first
        drop_all();
        push(32'h0003_0040, 32'hA1, 1);
        push(32'h0003_0044, 32'hA2, 1);
        push(32'h0003_0500, 32'hB1, 1);
        push(32'h0003_005C, 32'hA3, 1);
        inval(32'h0003_0050, 0, "R2");
        inval(32'h0003_0050, 2, "R2");
        inval(32'h0003_0050, 0, "R2");
        inval(32'h0003_0050, 0, "R4");   // line now empty
        drain("R2");

        // R7: full queue drops the push and keeps contents
        drop_all();
        for (int j = 0; j < DEPTH; j++) push(32'h0004_0000 + (j << 5), 32'hC0 + j, 1);
        push(32'h0005_0000, 32'hFF, 1);
        push(32'h0005_0020, 32'hFE, 0);
        inval(32'h0005_0000, 0, "R7");
        drain("R7");

        // R8: miss on a populated queue leaves it unchanged
        push(32'h0006_0000, 32'hD0, 1);
        push(32'h0006_0020, 32'hD1, 1);
        inval(32'h0006_0040, 0, "R8");
        drain("R8");

        // R9: all strobes at once -> discard wins
        push(32'h0007_0000, 32'hE0, 1);
        issue(1, 1, 1, 1, 32'h0007_0000, 32'h0007_0100, 32'hE1, 0, 0, "R9");
        inval(32'h0007_0000, 0, "R9");
        inval(32'h0007_0100, 0, "R9");
        // R9: invalidate beats push
        push(32'h0008_0000, 32'hF0, 1);
        issue(0, 1, 1, 1, 32'h0008_0000, 32'h0008_0100, 32'hF1, 0, 0, "R9");
        inval(32'h0008_0100, 0, "R9");

        // R10: commands during a pending write are ignored
        push(32'h0009_0000, 32'h90, 1);
        push(32'h0009_0020, 32'h91, 1);
        issue(0, 1, 0, 0, 32'h0009_0000, 0, 0, 3, 1, "R10");
        inval(32'h7FFF_FFE0, 0, "R10");
        drain("R10");

        // R6: discard leaves nothing to replay
        push(32'h000A_0000, 32'h55, 1);
        drop_all();
        inval(32'h000A_0000, 0, "R6");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule